// File: doc/BRIEF.md
# Linked-List Descriptor Reload Engine

When a DMA channel finishes a block, this engine decides how the channel goes on. It looks at the channel's link pointer register. That register holds six per-register reload flags and a word-aligned offset. If every flag and the offset are zero, the current descriptor is the final one. The engine then reports completion straight away and reads no memory.

In every other case, the engine forms the next descriptor's address. The upper half comes from the list base register and the lower half from the offset. It reads consecutive words from that address. Each word is handed to the channel as a load strobe with data, but only for the registers whose reload flag is set.

The transfer sequencer pulses a done input to start the engine. The engine drives a simple request/response memory read port. When it finishes, it signals completion. If a read fails, it signals a link error instead.

Top module: `link_item_loader`

## Requirements
- R1: While reset is held low, and on the cycle after it is released, the engine asserts no memory request, no load strobe, no completion, no last flag and no link error. All data outputs read zero.
- R2: The item is final when all six reload flags (pointer bits 31, 30, 29, 28, 27 and 16) are zero and the offset field (pointer bits 15:2) is zero. Pointer bits 1:0 play no part in this decision. For a final item, completion and last are both high for exactly one cycle, on the cycle after the start pulse is sampled. The engine makes no memory request and issues no strobe.
- R3: For a non-final item, the first read address is {base[31:16], pointer[15:2], 2'b00}. Base bits 15:0 are ignored. Each later read uses the previous read address plus 4.
- R4: Words are fetched and strobed in a fixed order, skipping any register whose flag is clear. The order, with each register's flag bit and strobe bit, is:
  - transfer config A: flag bit 31, strobe bit 0
  - transfer config B: flag bit 30, strobe bit 1
  - block length: flag bit 29, strobe bit 2
  - source address: flag bit 28, strobe bit 3
  - destination address: flag bit 27, strobe bit 4
  - link pointer: flag bit 16, strobe bit 5
- R5: Each error-free read response accepted at a clock edge produces exactly one strobe bit in the following cycle. In that cycle the data output equals the response data. No two strobe bits are ever high together.
- R6: For a non-final item, completion is high with last low for one cycle. That cycle comes one cycle after the final fetched strobe. If no flag is set, it comes two cycles after the start pulse.
- R7: If the link pointer flag (bit 16) is clear on a non-final item, the completion cycle also carries strobe bit 5 with data zero. The channel's pointer therefore becomes zero, and the next item is final.
- R8: A read response with the error input high produces a one-cycle link error pulse on the next cycle, with no strobe. After that, the engine drops its request, issues no more strobes and never signals completion for that item.
- R9: The pointer and base values are captured when the start pulse is sampled. Later changes to them, and start pulses that arrive while an item is still being handled, have no effect on that item's reads or strobes.
- R10: The memory request stays high, with a stable address, until a response is accepted. A response valid that arrives while no request is pending produces no strobe, no completion and no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| blk_done_i | input | 1 | Start pulse from the transfer sequencer |
| link_ptr_i | input | 32 | Channel link pointer register: reload flags and offset |
| list_base_i | input | 32 | List base register, base in bits 31:16 |
| mem_req_o | output | 1 | Memory read request, held until a response |
| mem_addr_o | output | 32 | Memory read byte address |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rdata_i | input | DATA_W | Read response data |
| mem_rerr_i | input | 1 | Read response error, qualified by valid |
| ld_strobe_o | output | 6 | One-hot register load strobe, bit order per R4 |
| ld_data_o | output | DATA_W | Data for the strobed register |
| done_o | output | 1 | Item handling complete |
| last_o | output | 1 | With done: the item was final |
| link_err_o | output | 1 | Read error during the descriptor fetch |

## Verification
Every result is due at a fixed distance from its cause:
- The completion for a final item arrives one cycle after the start edge.
- A strobe arrives one cycle after the edge that accepts its read response.
- A non-final completion arrives one cycle after the last fetched strobe, or two cycles after the start edge when nothing is fetched.
- A link error arrives one cycle after the failing response.

The bench samples a quarter cycle after each rising edge. It tags each sample with a cycle number and pairs every strobe with the response seen at that same edge. The memory model randomises its latency, so these distances are tested under variable delay.

// File: rtl/link_item_pkg.sv
`timescale 1ns/1ps
// Package: shared constants, state type and flag-bit map for the
// descriptor reload engine. Assumes a 32-bit register file.
package link_item_pkg;
    localparam int REG_W    = 32;
    localparam int NUM_REGS = 6;
    localparam int OFS_LO   = 2;
    localparam int BASE_LO  = 16;
    localparam int IDX_LINK = 5;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_FIN
    } ld_state_e;

    // Pointer bit carrying the reload flag of register slot idx (fetch order).
    function automatic int flag_pos(input int idx);
        case (idx)
            0:       return 31;
            1:       return 30;
            2:       return 29;
            3:       return 28;
            4:       return 27;
            default: return 16;
        endcase
    endfunction
endpackage

// File: rtl/link_item_decode.sv
`timescale 1ns/1ps
// Decoder: splits the link pointer into per-slot reload flags, builds the
// next descriptor address and flags a final item. Purely combinational.
// Assumes the base register holds the address upper half in its top bits.
module link_item_decode #(
    parameter int N = link_item_pkg::NUM_REGS,
    parameter int W = link_item_pkg::REG_W
) (
    input  logic [W-1:0] ptr,
    input  logic [W-1:0] base,
    output logic [N-1:0] upd,
    output logic [W-1:0] item_addr,
    output logic         is_last
);
    import link_item_pkg::*;

    // gather the reload flags in fetch order
    for (genvar g = 0; g < N; g++) begin : g_flag
        assign upd[g] = ptr[flag_pos(g)];
    end

    // base upper half joined with the word-aligned offset
    assign item_addr = {base[W-1:BASE_LO], ptr[BASE_LO-1:OFS_LO], {OFS_LO{1'b0}}};

    // final item: no flag and zero offset
    assign is_last = ~|upd && ~|ptr[BASE_LO-1:OFS_LO];

    logic unused_bits;
    assign unused_bits = ^{base[BASE_LO-1:0], ptr[OFS_LO-1:0], ptr[26:17]};
endmodule

// File: rtl/link_item_pick.sv
`timescale 1ns/1ps
// Picker: grants the lowest-indexed pending slot and returns what remains.
// Lowest index is fetched first. Purely combinational.
module link_item_pick #(
    parameter int N = link_item_pkg::NUM_REGS
) (
    input  logic [N-1:0] pend,
    output logic [N-1:0] grant,
    output logic [N-1:0] rest
);
    // isolate the lowest set bit
    assign grant = pend & (~pend + N'(1));
    // pending set after this grant
    assign rest  = pend & ~grant;
endmodule

// File: rtl/link_item_loader.sv
`timescale 1ns/1ps
// Top: on a block-done pulse, either reports a final item or fetches the
// next descriptor words in fixed order and strobes them into the channel
// registers whose reload flags are set. A read error aborts with a pulse.
// Assumes the memory holds the request until a response and returns one
// response per request; inputs are sampled at the rising edge.
module link_item_loader #(
    parameter int DATA_W = link_item_pkg::REG_W
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                blk_done_i,
    input  logic [link_item_pkg::REG_W-1:0]     link_ptr_i,
    input  logic [link_item_pkg::REG_W-1:0]     list_base_i,
    output logic                                mem_req_o,
    output logic [link_item_pkg::REG_W-1:0]     mem_addr_o,
    input  logic                                mem_rvalid_i,
    input  logic [DATA_W-1:0]                   mem_rdata_i,
    input  logic                                mem_rerr_i,
    output logic [link_item_pkg::NUM_REGS-1:0]  ld_strobe_o,
    output logic [DATA_W-1:0]                   ld_data_o,
    output logic                                done_o,
    output logic                                last_o,
    output logic                                link_err_o
);
    import link_item_pkg::*;

    localparam int N = NUM_REGS;
    localparam logic [REG_W-1:0] WORD_BYTES = REG_W'(REG_W / 8);
    localparam logic [N-1:0]     LINK_MASK  = N'(1) << IDX_LINK;

    ld_state_e         state;
    logic [N-1:0]      pend;
    logic              keep_link;
    logic [N-1:0]      upd;
    logic [REG_W-1:0]  item_addr;
    logic              is_last;
    logic [N-1:0]      grant;
    logic [N-1:0]      rest;

    link_item_decode #(.N(N), .W(REG_W)) u_decode (
        .ptr      (link_ptr_i),
        .base     (list_base_i),
        .upd      (upd),
        .item_addr(item_addr),
        .is_last  (is_last)
    );

    link_item_pick #(.N(N)) u_pick (
        .pend (pend),
        .grant(grant),
        .rest (rest)
    );

    // request is live exactly while words remain to be fetched
    assign mem_req_o = (state == ST_FETCH);

    // sequencer: capture, fetch loop, completion and error abort
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            pend        <= '0;
            keep_link   <= 1'b0;
            mem_addr_o  <= '0;
            ld_strobe_o <= '0;
            ld_data_o   <= '0;
            done_o      <= 1'b0;
            last_o      <= 1'b0;
            link_err_o  <= 1'b0;
        end else begin
            ld_strobe_o <= '0;
            ld_data_o   <= '0;
            done_o      <= 1'b0;
            last_o      <= 1'b0;
            link_err_o  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (blk_done_i) begin
                        if (is_last) begin
                            done_o <= 1'b1;
                            last_o <= 1'b1;
                        end else begin
                            pend       <= upd;
                            keep_link  <= upd[IDX_LINK];
                            mem_addr_o <= item_addr;
                            state      <= (|upd) ? ST_FETCH : ST_FIN;
                        end
                    end
                end
                ST_FETCH: begin
                    if (mem_rvalid_i) begin
                        if (mem_rerr_i) begin
                            link_err_o <= 1'b1;
                            pend       <= '0;
                            state      <= ST_IDLE;
                        end else begin
                            ld_strobe_o <= grant;
                            ld_data_o   <= mem_rdata_i;
                            pend        <= rest;
                            mem_addr_o  <= mem_addr_o + WORD_BYTES;
                            if (rest == '0) state <= ST_FIN;
                        end
                    end
                end
                ST_FIN: begin
                    done_o <= 1'b1;
                    if (!keep_link) ld_strobe_o <= LINK_MASK;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R5
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ld_strobe_o));

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));

    // R2
    last_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> done_o);

    // R8
    err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_err_o |-> (!done_o && ld_strobe_o == '0 && !mem_req_o));

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && $past(mem_req_o && mem_rvalid_i && !mem_rerr_i))
        |-> (mem_addr_o == $past(mem_addr_o) + WORD_BYTES));

    // R7
    done_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((ld_strobe_o & ~LINK_MASK) == '0 && ld_data_o == '0));
endmodule

// File: tb/link_item_loader_tb.sv
`timescale 1ns/1ps
module link_item_loader_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        blk_done = 1'b0;
    logic [31:0] link_ptr = '0;
    logic [31:0] list_base = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_rerr = 1'b0;
    logic [5:0]  ld_strobe;
    logic [31:0] ld_data;
    logic        done, last, link_err;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    link_item_loader u_dut (
        .clk(clk), .rst_n(rst_n), .blk_done_i(blk_done),
        .link_ptr_i(link_ptr), .list_base_i(list_base),
        .mem_req_o(mem_req), .mem_addr_o(mem_addr),
        .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata), .mem_rerr_i(mem_rerr),
        .ld_strobe_o(ld_strobe), .ld_data_o(ld_data),
        .done_o(done), .last_o(last), .link_err_o(link_err)
    );

    function automatic logic [31:0] memf(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    endfunction

    function automatic int fpos(input int i);
        case (i)
            0: return 31; 1: return 30; 2: return 29;
            3: return 28; 4: return 27; default: return 16;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // memory model controls
    bit          err_en = 1'b0;
    logic [31:0] err_addr = '0;
    int          lat_max = 0;

    // memory model: one response per held request, random latency
    initial begin
        int wait_n;
        wait_n = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                mem_rvalid = 1'b0;
                mem_rerr   = 1'b0;
            end else if (mem_rvalid) begin
                mem_rvalid = 1'b0;
                mem_rerr   = 1'b0;
                wait_n     = $urandom_range(lat_max, 0);
            end else if (mem_req) begin
                if (wait_n == 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = memf(mem_addr);
                    mem_rerr   = err_en && (mem_addr == err_addr);
                end else begin
                    wait_n--;
                end
            end
        end
    end

    // monitor state
    int          cyc = 0;
    bit          prev_req = 1'b0;
    logic [31:0] prev_addr = '0;
    int          n_st, n_ad, done_cyc, last_fetch_cyc, req_cnt;
    int          st_idx [16];
    logic [31:0] st_dat [16];
    logic [31:0] ad_log [16];
    bit          saw_done, saw_last, saw_err;

    // monitor: samples a quarter cycle after each rising edge
    initial begin
        forever begin
            bit         acc;
            logic [5:0] fst;
            @(posedge clk);
            #5;
            cyc++;
            if (rst_n) begin
                acc = prev_req && mem_rvalid && !mem_rerr;
                if (prev_req && mem_rvalid && n_ad < 16) begin
                    ad_log[n_ad] = prev_addr;
                    n_ad++;
                end
                fst = done ? (ld_strobe & 6'b011111) : ld_strobe;
                if (acc || fst != 0) begin
                    // R5 strobe follows accepted response with its data
                    chk(acc && fst != 0 && ld_data == mem_rdata, "R5",
                        "strobe vs response", ld_data, mem_rdata);
                    if (fst != 0) last_fetch_cyc = cyc;
                end
                for (int b = 0; b < 6; b++) begin
                    if (ld_strobe[b] && n_st < 16) begin
                        st_idx[n_st] = b;
                        st_dat[n_st] = ld_data;
                        n_st++;
                    end
                end
                if (done) begin
                    saw_done = 1'b1;
                    saw_last = last;
                    done_cyc = cyc;
                end
                if (link_err) saw_err = 1'b1;
                if (mem_req) req_cnt++;
            end
            prev_req  = mem_req;
            prev_addr = mem_addr;
        end
    end

    // run one item and compare against the expectation built from the requirements
    task automatic run_item(input logic [31:0] l, input logic [31:0] b,
                            input bit e_en, input int e_sel, input bit poke);
        bit [5:0]    f;
        logic [31:0] base;
        bit          exp_last, exp_err;
        int          nf_tot, e_word, k, n_exp, n_adx, start_cyc, exp_done;
        int          e_idx [8];
        logic [31:0] e_dat [8];
        for (int i = 0; i < 6; i++) f[i] = l[fpos(i)];
        base     = {b[31:16], l[15:2], 2'b00};
        exp_last = (f == 0) && (l[15:2] == 0);
        nf_tot   = $countones(f);
        exp_err  = e_en && nf_tot > 0;
        e_word   = (nf_tot > 0) ? (e_sel % nf_tot) : 0;
        k = 0; n_exp = 0;
        for (int i = 0; i < 6; i++) begin
            if (f[i]) begin
                if (!exp_err || k < e_word) begin
                    e_idx[n_exp] = i;
                    e_dat[n_exp] = memf(base + 32'(4 * k));
                    n_exp++;
                end
                k++;
            end
        end
        n_adx = exp_last ? 0 : (exp_err ? e_word + 1 : nf_tot);
        if (!exp_err && !exp_last && !f[5]) begin
            e_idx[n_exp] = 5;
            e_dat[n_exp] = '0;
            n_exp++;
        end

        @(negedge clk);
        n_st = 0; n_ad = 0; req_cnt = 0; last_fetch_cyc = -1; done_cyc = -1;
        saw_done = 0; saw_last = 0; saw_err = 0;
        err_en   = exp_err;
        err_addr = base + 32'(4 * e_word);
        link_ptr = l; list_base = b; blk_done = 1'b1;
        start_cyc = cyc;
        @(negedge clk);
        blk_done = 1'b0;
        if (poke && !exp_last) begin
            link_ptr = $urandom; list_base = $urandom; blk_done = 1'b1;
            @(negedge clk);
            blk_done = 1'b0;
        end
        for (int t = 0; t < 300 && !(saw_done || saw_err); t++) @(negedge clk);
        repeat (3) @(negedge clk);

        if (exp_err) begin
            chk(saw_err, "R8", "link error seen", 32'(saw_err), 1);
            chk(!saw_done, "R8", "no done after error", 32'(saw_done), 0);
            chk(!mem_req, "R8", "request dropped", 32'(mem_req), 0);
        end else begin
            chk(saw_done, "R6", "done seen", 32'(saw_done), 1);
            chk(saw_last == exp_last, "R2", "last flag", 32'(saw_last), 32'(exp_last));
            chk(!saw_err, "R8", "no spurious error", 32'(saw_err), 0);
            chk(!mem_req, "R10", "request low after done", 32'(mem_req), 0);
            if (exp_last) begin
                chk(done_cyc == start_cyc + 1, "R2", "final done timing", 32'(done_cyc), 32'(start_cyc + 1));
                chk(req_cnt == 0, "R2", "no read for final item", 32'(req_cnt), 0);
            end else begin
                exp_done = (nf_tot > 0) ? last_fetch_cyc + 1 : start_cyc + 2;
                chk(done_cyc == exp_done, "R6", "done timing", 32'(done_cyc), 32'(exp_done));
            end
            if (!exp_last && !f[5])
                chk(n_st > 0 && st_idx[n_st-1] == 5 && st_dat[n_st-1] == 0, "R7",
                    "pointer cleared", 32'(n_st), 32'(n_exp));
        end
        chk(n_st == n_exp, poke ? "R9" : "R4", "strobe count", 32'(n_st), 32'(n_exp));
        for (int i = 0; i < n_exp && i < n_st; i++) begin
            chk(st_idx[i] == e_idx[i], "R4", "strobe order", 32'(st_idx[i]), 32'(e_idx[i]));
            chk(st_dat[i] == e_dat[i], "R4", "strobe data", st_dat[i], e_dat[i]);
        end
        chk(n_ad == n_adx, poke ? "R9" : "R3", "read count", 32'(n_ad), 32'(n_adx));
        for (int i = 0; i < n_adx && i < n_ad; i++)
            chk(ad_log[i] == base + 32'(4 * i), "R3", "read address", ad_log[i], base + 32'(4 * i));
        err_en = 1'b0;
    endtask

    // watchdog
    initial begin
        #3000000;
        checks++; errors++;
        $display("FAIL watchdog expired act=%0d exp=0", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(!mem_req && ld_strobe == 0 && !done && !last && !link_err, "R1",
            "outputs in reset", {26'd0, ld_strobe}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_req && ld_strobe == 0 && ld_data == 0 && mem_addr == 0 && !done && !link_err,
            "R1", "outputs after reset", mem_addr, 0);

        // R10 stray response while idle has no effect
        @(negedge clk);
        #2 mem_rvalid = 1'b1; mem_rdata = 32'hDEADBEEF; mem_rerr = 1'b0;
        @(posedge clk); #5;
        chk(ld_strobe == 0 && !done && !link_err, "R10", "stray response ignored",
            {26'd0, ld_strobe}, 0);

        // R2 final item, reserved pointer bits set
        lat_max = 0;
        run_item(32'h0000_0003, 32'hABCD_1234, 0, 0, 0);
        // all flags, offset at top, R3 base low half ignored
        lat_max = 2;
        run_item(32'hF801_FFFC, 32'h1234_FFFF, 0, 0, 0);
        // R7 no flags, nonzero offset
        run_item(32'h0000_0040, 32'h2000_0000, 0, 0, 0);
        // link pointer only
        run_item(32'h0001_0010, 32'h3000_0000, 0, 0, 0);
        // R8 error on third word
        lat_max = 1;
        run_item(32'hF801_0100, 32'h4000_0000, 1, 2, 0);
        // R8 error on first word
        run_item(32'h0800_0200, 32'h4000_0000, 1, 0, 0);
        // R9 start and input changes while busy
        lat_max = 3;
        run_item(32'hA801_0020, 32'h5000_0000, 0, 0, 1);
        run_item(32'h0000_0008, 32'h5000_0000, 0, 0, 1);

        // constrained random items
        for (int n = 0; n < 40; n++) begin
            logic [31:0] l;
            l = $urandom;
            if ($urandom_range(3, 0) == 0) l = l & 32'h0001_FFFF;
            if ($urandom_range(7, 0) == 0) l = l & 32'h0000_0003;
            lat_max = $urandom_range(3, 0);
            run_item(l, $urandom, $urandom_range(4, 0) == 0, $urandom_range(5, 0),
                     $urandom_range(3, 0) == 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule